// File: doc/BRIEF.md
# Long Multiply-Accumulate Unit

This execution unit forms the double-width product of two operands and can add that product to a double-width accumulator. Two control bits select one of four operations. One bit picks unsigned or two's complement interpretation. The other bit picks plain multiply or multiply-accumulate. The accumulator comes in as separate low and high words. The result goes out the same way, so it can be written straight into a pair of destination registers.

The unit is fully pipelined. An operation presented with `in_valid_i` appears two cycles later, marked by `out_valid_o`, and a new operation can start every cycle. The caller passes in the current flag state with each operation. When flag update is requested, the held flag output replaces N and Z with values taken from the result and copies C and V through unchanged. When flag update is not requested, the incoming flags are copied through as they are. The flag output holds its value between results.

Top module: `mul_long_unit`

## Requirements
- R1: With `signed_i`=0 and `accum_i`=0, the result is the unsigned product of `op_a_i` and `op_b_i`. The low OP_W bits go to `res_lo_o` and the high OP_W bits go to `res_hi_o`.
- R2: With `signed_i`=1 and `accum_i`=0, both operands are treated as two's complement and the full signed product is returned as low/high halves. For example, the most negative value squared gives 2^(2·OP_W−2).
- R3: With `signed_i`=0 and `accum_i`=1, the result is (product + {`acc_hi_i`,`acc_lo_i`}) mod 2^(2·OP_W). No carry-out is reported.
- R4: With `signed_i`=1 and `accum_i`=1, the signed product is added to the accumulator read as a two's complement value, wrapping modulo 2^(2·OP_W).
- R5: With `accum_i`=0, the accumulator inputs have no effect on the result.
- R6: `flags_o` is {N,Z,C,V} with N at bit 3. When `set_flags_i`=1, N equals bit 2·OP_W−1 of the result, and Z is 1 exactly when all result bits are zero.
- R7: C (`flags_o[1]`) and V (`flags_o[0]`) always equal the C and V given in `flags_i` with that operation, even when `set_flags_i`=1.
- R8: With `set_flags_i`=0, `flags_o` equals the `flags_i` value presented with the operation.
- R9: An operation accepted in cycle t produces its result with `out_valid_o`=1 in cycle t+2. Back-to-back operations are accepted every cycle. `out_valid_o` is 0 in cycles that carry no result.
- R10: Reset drives `out_valid_o` and `flags_o` to zero. `flags_o` changes only in cycles where `out_valid_o`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Operation present this cycle |
| signed_i | input | 1 | 1: two's complement operands and accumulator |
| accum_i | input | 1 | 1: add accumulator to product |
| set_flags_i | input | 1 | 1: update N and Z from the result |
| op_a_i | input | OP_W | First operand |
| op_b_i | input | OP_W | Second operand |
| acc_lo_i | input | OP_W | Accumulator low word |
| acc_hi_i | input | OP_W | Accumulator high word |
| flags_i | input | 4 | Current {N,Z,C,V} |
| out_valid_o | output | 1 | Result present this cycle |
| res_lo_o | output | OP_W | Result low word |
| res_hi_o | output | OP_W | Result high word |
| flags_o | output | 4 | Held {N,Z,C,V} |

## Verification
The assertions assume two things about the inputs: that control, operand and flag inputs are at known values in every cycle after reset, and that the mode bits seen together with a valid input belong to that operation. The stimulus drives every input on the falling edge and never leaves one undriven. Between bursts it inserts idle cycles with `in_valid_i` low, which exercises the hold behaviour of the flags. The bench uses an 8-bit operand width. It sweeps every first operand against a spread of second operands, cycling through all four modes. Accumulators and incoming flags are random. Directed wrap and most-negative cases are applied before the sweep.

// File: rtl/mlu_pkg.sv
package mlu_pkg;
  localparam int FLAG_W = 4;
  localparam int FLG_N  = 3;
  localparam int FLG_Z  = 2;
  localparam int FLG_C  = 1;
  localparam int FLG_V  = 0;
endpackage

// File: rtl/mlu_mul_stage.sv
module mlu_mul_stage #(
  parameter int OP_W  = 32,
  localparam int RES_W = 2 * OP_W
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     valid_i,
  input  logic                     signed_i,
  input  logic                     accum_i,
  input  logic                     set_i,
  input  logic [OP_W-1:0]          a_i,
  input  logic [OP_W-1:0]          b_i,
  input  logic [OP_W-1:0]          acc_lo_i,
  input  logic [OP_W-1:0]          acc_hi_i,
  input  logic [mlu_pkg::FLAG_W-1:0] flags_i,
  output logic                     valid_o,
  output logic                     set_o,
  output logic [RES_W-1:0]         prod_o,
  output logic [RES_W-1:0]         addend_o,
  output logic [mlu_pkg::FLAG_W-1:0] flags_o
);
  // one extra bit lets a single signed multiplier cover both modes
  logic signed [OP_W:0]    a_x, b_x;
  logic signed [RES_W+1:0] p_full;
  logic [RES_W-1:0]        addend;

  always_comb begin
    a_x    = {signed_i & a_i[OP_W-1], a_i};
    b_x    = {signed_i & b_i[OP_W-1], b_i};
    p_full = a_x * b_x;
    addend = accum_i ? {acc_hi_i, acc_lo_i} : '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      set_o    <= 1'b0;
      prod_o   <= '0;
      addend_o <= '0;
      flags_o  <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        set_o    <= set_i;
        prod_o   <= p_full[RES_W-1:0];
        addend_o <= addend;
        flags_o  <= flags_i;
      end
    end
  end
endmodule

// File: rtl/mlu_acc_stage.sv
module mlu_acc_stage #(
  parameter int OP_W  = 32,
  localparam int RES_W = 2 * OP_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [RES_W-1:0] prod_i,
  input  logic [RES_W-1:0] addend_i,
  output logic [RES_W-1:0] sum_o,
  output logic             valid_o,
  output logic [RES_W-1:0] res_o
);
  // modulo 2^RES_W: carry-out dropped by width
  assign sum_o = prod_i + addend_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      res_o   <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) res_o <= sum_o;
    end
  end
endmodule

// File: rtl/mlu_flag_reg.sv
module mlu_flag_reg #(
  parameter int RES_W = 64
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       en_i,
  input  logic                       set_i,
  input  logic [RES_W-1:0]           res_i,
  input  logic [mlu_pkg::FLAG_W-1:0] flags_i,
  output logic [mlu_pkg::FLAG_W-1:0] flags_o
);
  import mlu_pkg::*;
  logic [FLAG_W-1:0] nxt;

  always_comb begin
    nxt = flags_i;
    if (set_i) begin
      nxt[FLG_N] = res_i[RES_W-1];
      nxt[FLG_Z] = ~|res_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   flags_o <= '0;
    else if (en_i) flags_o <= nxt;
  end
endmodule

// File: rtl/mul_long_unit.sv
module mul_long_unit #(
  parameter int OP_W = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            in_valid_i,
  input  logic            signed_i,
  input  logic            accum_i,
  input  logic            set_flags_i,
  input  logic [OP_W-1:0] op_a_i,
  input  logic [OP_W-1:0] op_b_i,
  input  logic [OP_W-1:0] acc_lo_i,
  input  logic [OP_W-1:0] acc_hi_i,
  input  logic [3:0]      flags_i,
  output logic            out_valid_o,
  output logic [OP_W-1:0] res_lo_o,
  output logic [OP_W-1:0] res_hi_o,
  output logic [3:0]      flags_o
);
  import mlu_pkg::*;
  localparam int RES_W = 2 * OP_W;

  logic              s1_valid, s1_set;
  logic [RES_W-1:0]  s1_prod, s1_addend, s2_sum, s2_res;
  logic [FLAG_W-1:0] s1_flags;

  mlu_mul_stage #(.OP_W(OP_W)) u_mul (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .valid_i  (in_valid_i),
    .signed_i (signed_i),
    .accum_i  (accum_i),
    .set_i    (set_flags_i),
    .a_i      (op_a_i),
    .b_i      (op_b_i),
    .acc_lo_i (acc_lo_i),
    .acc_hi_i (acc_hi_i),
    .flags_i  (flags_i),
    .valid_o  (s1_valid),
    .set_o    (s1_set),
    .prod_o   (s1_prod),
    .addend_o (s1_addend),
    .flags_o  (s1_flags)
  );

  mlu_acc_stage #(.OP_W(OP_W)) u_acc (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .valid_i  (s1_valid),
    .prod_i   (s1_prod),
    .addend_i (s1_addend),
    .sum_o    (s2_sum),
    .valid_o  (out_valid_o),
    .res_o    (s2_res)
  );

  mlu_flag_reg #(.RES_W(RES_W)) u_flg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (s1_valid),
    .set_i   (s1_set),
    .res_i   (s2_sum),
    .flags_i (s1_flags),
    .flags_o (flags_o)
  );

  assign res_lo_o = s2_res[OP_W-1:0];
  assign res_hi_o = s2_res[RES_W-1:OP_W];
endmodule

// File: rtl/mlu_chk.sv
module mlu_chk #(
  parameter int OP_W = 32
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            in_valid_i,
  input logic            signed_i,
  input logic            accum_i,
  input logic            set_flags_i,
  input logic [OP_W-1:0] op_a_i,
  input logic [OP_W-1:0] op_b_i,
  input logic [3:0]      flags_i,
  input logic            out_valid_o,
  input logic [OP_W-1:0] res_lo_o,
  input logic [OP_W-1:0] res_hi_o,
  input logic [3:0]      flags_o
);
  logic [1:0] cyc;
  logic [2*OP_W-1:0] res;
  assign res = {res_hi_o, res_lo_o};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         cyc <= '0;
    else if (cyc != 2'd3) cyc <= cyc + 2'd1;
  end

  // R9
  latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc >= 2'd2) |-> (out_valid_o == $past(in_valid_i, 2)));

  // R10
  flag_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc >= 2'd1 && !out_valid_o) |-> $stable(flags_o));

  // R7
  cv_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc >= 2'd2 && out_valid_o) |-> (flags_o[1:0] == $past(flags_i[1:0], 2)));

  // R6
  nz_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc >= 2'd2 && out_valid_o && $past(set_flags_i, 2)) |->
      (flags_o[3] == res[2*OP_W-1] && flags_o[2] == (res == '0)));

  // R8
  no_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc >= 2'd2 && out_valid_o && !$past(set_flags_i, 2)) |->
      (flags_o == $past(flags_i, 2)));

  // R1
  umul_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc >= 2'd2 && out_valid_o && !$past(signed_i, 2) && !$past(accum_i, 2)) |->
      (res == {{OP_W{1'b0}}, $past(op_a_i, 2)} * {{OP_W{1'b0}}, $past(op_b_i, 2)}));
endmodule

bind mul_long_unit mlu_chk #(.OP_W(OP_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .in_valid_i  (in_valid_i),
  .signed_i    (signed_i),
  .accum_i     (accum_i),
  .set_flags_i (set_flags_i),
  .op_a_i      (op_a_i),
  .op_b_i      (op_b_i),
  .flags_i     (flags_i),
  .out_valid_o (out_valid_o),
  .res_lo_o    (res_lo_o),
  .res_hi_o    (res_hi_o),
  .flags_o     (flags_o)
);

// File: tb/mul_long_unit_bench.sv
module mul_long_unit_bench;
  localparam int W  = 8;
  localparam int RW = 2 * W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic         vld = 1'b0, sgn = 1'b0, acc = 1'b0, setf = 1'b0;
  logic [W-1:0] a = '0, b = '0, lo = '0, hi = '0;
  logic [3:0]   fi = '0;
  logic         out_v;
  logic [W-1:0] r_lo, r_hi;
  logic [3:0]   fo;

  mul_long_unit #(.OP_W(W)) u_mul_long_unit (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(vld), .signed_i(sgn),
    .accum_i(acc), .set_flags_i(setf), .op_a_i(a), .op_b_i(b),
    .acc_lo_i(lo), .acc_hi_i(hi), .flags_i(fi),
    .out_valid_o(out_v), .res_lo_o(r_lo), .res_hi_o(r_hi), .flags_o(fo)
  );

  typedef struct {
    logic [RW-1:0] res;
    logic [3:0]    fl;
    string         rt;
    string         ft;
  } exp_t;

  exp_t       q[$];
  logic [1:0] sh = '0;
  logic [3:0] last_fl = '0;
  int         n_chk = 0, n_bad = 0;
  bit         started = 0;

  task automatic chk(bit ok, string tag, logic [RW-1:0] act, logic [RW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic issue(bit s, bit ac, bit sf, logic [W-1:0] ia, logic [W-1:0] ib,
                       logic [W-1:0] il, logic [W-1:0] ih, logic [3:0] ifl);
    exp_t   e;
    longint pa, pb, pacc, r;
    @(negedge clk);
    vld = 1'b1; sgn = s; acc = ac; setf = sf;
    a = ia; b = ib; lo = il; hi = ih; fi = ifl;
    pa   = s ? longint'($signed(ia)) : longint'(ia);
    pb   = s ? longint'($signed(ib)) : longint'(ib);
    pacc = longint'({ih, il});
    r    = pa * pb + (ac ? pacc : 64'sd0);
    e.res = r[RW-1:0];
    e.fl  = ifl;
    if (sf) begin
      e.fl[3] = e.res[RW-1];
      e.fl[2] = (e.res == '0);
    end
    e.rt = s ? (ac ? "R4" : "R2") : (ac ? "R3" : "R1");
    if (!ac) e.rt = {e.rt, "/R5"};
    e.ft = sf ? "R6/R7" : "R8/R7";
    q.push_back(e);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      vld = 1'b0;
      a = W'($urandom); fi = 4'($urandom);
    end
  endtask

  always @(posedge clk) sh <= {sh[0], vld};

  always @(posedge clk) begin : mon
    exp_t e;
    #5;
    if (started) begin
      if (sh[1]) begin
        e = q.pop_front();
        chk(out_v == 1'b1, "R9 valid", RW'(out_v), RW'(1));
        chk({r_hi, r_lo} == e.res, e.rt, {r_hi, r_lo}, e.res);
        chk(fo == e.fl, e.ft, RW'(fo), RW'(e.fl));
        last_fl = e.fl;
      end else begin
        chk(out_v == 1'b0, "R9 idle", RW'(out_v), RW'(0));
        chk(fo == last_fl, "R10 hold", RW'(fo), RW'(last_fl));
      end
    end
  end

  initial begin : wdog
    #(20 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(out_v == 1'b0, "R10 reset valid", RW'(out_v), RW'(0));
    chk(fo == 4'b0, "R10 reset flags", RW'(fo), RW'(0));
    rst_n = 1'b1;
    started = 1;
    // directed corners
    issue(1, 0, 1, 8'h80, 8'h80, 8'hAA, 8'h55, 4'b0011);  // R2: 0x4000
    issue(0, 0, 1, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 4'b1110);  // R1: 0xFE01
    issue(0, 1, 1, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 4'b0001);  // R3 wrap: 0xFE00
    issue(1, 1, 1, 8'h80, 8'h80, 8'h00, 8'hC0, 4'b1111);  // R4 wrap to zero, Z
    issue(1, 0, 1, 8'h7F, 8'h80, 8'h12, 8'h34, 4'b0000);  // R6 negative
    issue(0, 0, 0, 8'h00, 8'h9C, 8'hFF, 8'hFF, 4'b1010);  // R8/R5
    idle(3);
    issue(0, 1, 0, 8'h01, 8'h01, 8'hFF, 8'hFF, 4'b0101);  // R3 wrap to 0
    idle(2);
    // sweep
    for (int ia = 0; ia < 256; ia++) begin
      for (int bi = 0; bi < 52; bi++) begin
        int m;
        m = (ia + bi) % 8;
        issue(m[0], m[1], m[2], W'(ia), (bi == 51) ? 8'hFF : W'(bi * 5),
              W'($urandom), W'($urandom), 4'($urandom));
        if (((ia * 52 + bi) % 97) == 0) idle(1 + (bi % 3));
      end
    end
    idle(5);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule